// File: doc/BRIEF.md
# Sequenced parameter programming port

This block is a write-only, 16-bit host port that loads configuration words into four parameter banks. The host never sends a slot address. The upper bits of each word carry a start-of-bank marker and a bank selector. Each bank keeps its own pointer, and that pointer decides which slot the data field lands in. A start word rewinds its bank to slot 0, and each continuation word moves on to the next slot. The host may stop partway through a bank; the slots it did not reach keep their values. The host may also move between banks in any order.

Each accepted word starts a busy period of `BUSY_CYC` clock cycles, during which the ready flag is low. A word is refused when any of the following holds:

- the ready flag is low;
- the receive or transmit path is active;
- a processing, clock or override enable is missing;
- the word selects the reserved bank;
- the word continues a bank that was never started;
- the word would run past the bank's slot count.

A refused word changes no storage and raises a sticky error flag. A combinational read port exposes every slot to the logic that uses the parameters.

Top module: `prog_port`

## Requirements
- R1: After reset every slot holds its default value, which is bank_index*256 + slot, with bank_index 0, 1, 2, 3 for banks 0, 1, 2 and 4. After reset, ready_o is 1 and err_o is 0.
- R2: An accepted word with bit 15 = 1 stores its data field in slot 0 of the selected bank and sets that bank's pointer so that the next continuation goes to slot 1.
- R3: An accepted word with bit 15 = 0 stores its data field at the selected bank's pointer, then advances that pointer by one.
- R4: Bank decode works as follows. If bit 14 = 1, bits 13:12 select the bank: 00 is bank 0, 01 is bank 1 and 10 is bank 2, each with a 12-bit field in bits 11:0. If bit 14 = 0, the word goes to bank 4, with a 14-bit field in bits 13:0. On rd_bank_i, code 3 reads bank 4.
- R5: Bits 14:12 = 111 select a reserved bank. Such a word is refused.
- R6: ready_o goes to 0 in the cycle after an accepted word. It returns to 1 exactly BUSY_CYC clock cycles after the accepting edge.
- R7: A word written while ready_o is 0 is refused and leaves all storage unchanged.
- R8: A word is refused unless rx_en_i = 0, tx_en_i = 0, proc_en_i = 1, clk_en_i = 1 and ovr_en_i = 1.
- R9: A continuation word for a bank that has had no start word since reset is refused.
- R10: A continuation that would pass the bank's slot count is refused. The counts are 8, 4, 4 and 8 for banks 0, 1, 2 and 4, so slot 8 of bank 4 is never written.
- R11: Each bank keeps its own pointer. Interleaving banks does not disturb any bank's sequence, and slots that were not reached keep their values.
- R12: Any refused word sets err_o on the next edge. err_o stays set until err_clr_i is high without a refused word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Programming word strobe |
| wr_data_i | input | 16 | Programming word |
| rx_en_i | input | 1 | Receive path active |
| tx_en_i | input | 1 | Transmit path active |
| proc_en_i | input | 1 | Processing enabled |
| clk_en_i | input | 1 | Core clock enabled |
| ovr_en_i | input | 1 | Parameter override enabled |
| err_clr_i | input | 1 | Clears the sticky error flag |
| rd_bank_i | input | 2 | Read bank select (3 = bank 4) |
| rd_word_i | input | 4 | Read slot index |
| ready_o | output | 1 | High when a new word may be written |
| err_o | output | 1 | Sticky flag for a refused word |
| rd_data_o | output | 14 | Selected slot, zero-extended |

## Verification
The bench counts the exact number of cycles ready_o stays low. A counter that is off by one would release the host a cycle early or late.

The bench writes a word while the port is busy and checks that the earlier data survives. A design that gated only on the enables would overwrite it.

The bench also covers three further cases:

- **Bank 4 overflow.** It fills bank 4 and pushes one more word. A pointer compare written as `<=` would spill into the reserved test slot or wrap onto slot 0.
- **Pointer sharing.** It interleaves banks and restarts a bank partway through. A single shared pointer would misplace words, and a missing rewind would append instead of restarting.
- **Bit 14 decode.** It uses field values that show whether bit 12 or bit 13 leaks into a 12-bit bank, or whether the decode of bit 14 is inverted.

// File: rtl/prog_pkg.sv
package prog_pkg;
  typedef enum logic [1:0] {BK0 = 2'd0, BK1 = 2'd1, BK2 = 2'd2, BK4 = 2'd3} bank_e;

  localparam int unsigned FIELD_W = 14;

  function automatic logic [FIELD_W-1:0] slot_default(input int unsigned idx, input int unsigned w);
    return FIELD_W'(idx * 256 + w);
  endfunction
endpackage

// File: rtl/prog_decode.sv
module prog_decode
  import prog_pkg::*;
(
  input  logic [15:0]        word_i,
  output logic               first_o,
  output bank_e              bank_o,
  output logic               rsvd_o,
  output logic [FIELD_W-1:0] field_o
);
  always_comb begin
    first_o = word_i[15];
    rsvd_o  = 1'b0;
    if (word_i[14]) begin
      bank_o  = bank_e'(word_i[13:12]);
      rsvd_o  = (word_i[13:12] == 2'b11);
      field_o = {2'b00, word_i[11:0]};
    end else begin
      bank_o  = BK4;
      field_o = word_i[13:0];
    end
  end
endmodule

// File: rtl/prog_busy.sv
module prog_busy #(
  parameter int unsigned BUSY_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  // R6: busy window shrinks by one each cycle
  a_r6_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r6_ready_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(1) && !start_i) |=> ready_o);
endmodule

// File: rtl/prog_bank.sv
module prog_bank
  import prog_pkg::*;
#(
  parameter int unsigned IDX   = 0,
  parameter int unsigned WORDS = 8,
  parameter int unsigned DW    = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               first_i,
  input  logic               cont_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [3:0]         rd_word_i,
  output logic [FIELD_W-1:0] rd_data_o,
  output logic               can_cont_o
);
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned PW = $clog2(WORDS + 1);

  logic [DW-1:0] mem_q [WORDS];
  logic [PW-1:0] ptr_q;
  logic          open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      ptr_q  <= '0;
      for (int i = 0; i < WORDS; i++) mem_q[i] <= DW'(slot_default(IDX, i));
    end else if (first_i) begin
      mem_q[0] <= field_i[DW-1:0];
      ptr_q    <= PW'(1);
      open_q   <= 1'b1;
    end else if (cont_i) begin
      mem_q[ptr_q[AW-1:0]] <= field_i[DW-1:0];
      ptr_q                <= ptr_q + 1'b1;
    end
  end

  assign can_cont_o = open_q && (ptr_q < PW'(WORDS));

  always_comb begin
    rd_data_o = '0;
    if (rd_word_i < 4'(WORDS)) rd_data_o = FIELD_W'(mem_q[rd_word_i[AW-1:0]]);
  end

  a_r10_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PW'(WORDS));
  a_r2_first_rewinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_i |=> (ptr_q == PW'(1)) && (mem_q[0] == $past(field_i[DW-1:0])));
  a_r3_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont_i && !first_i) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/prog_port.sv
module prog_port
  import prog_pkg::*;
#(
  parameter int unsigned BUSY_CYC = 1000,
  parameter int unsigned B0_WORDS = 8,
  parameter int unsigned B1_WORDS = 4,
  parameter int unsigned B2_WORDS = 4,
  parameter int unsigned B4_WORDS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        rx_en_i,
  input  logic        tx_en_i,
  input  logic        proc_en_i,
  input  logic        clk_en_i,
  input  logic        ovr_en_i,
  input  logic        err_clr_i,
  input  logic [1:0]  rd_bank_i,
  input  logic [3:0]  rd_word_i,
  output logic        ready_o,
  output logic        err_o,
  output logic [13:0] rd_data_o
);
  localparam int unsigned NBANK = 4;

  logic               first;
  bank_e              bank;
  logic               rsvd;
  logic [FIELD_W-1:0] field;
  logic               ready;
  logic               permit, legal, accept, reject;
  logic               err_q;
  logic [NBANK-1:0]   can_cont, we_first, we_cont;
  logic [NBANK-1:0][FIELD_W-1:0] rd_all;

  prog_decode u_dec (
    .word_i (wr_data_i),
    .first_o(first),
    .bank_o (bank),
    .rsvd_o (rsvd),
    .field_o(field)
  );

  prog_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .ready_o(ready)
  );

  assign permit = !rx_en_i && !tx_en_i && proc_en_i && clk_en_i && ovr_en_i;
  assign legal  = ready && permit && !rsvd && (first || can_cont[bank]);
  assign accept = wr_en_i && legal;
  assign reject = wr_en_i && !legal;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam int unsigned NW = (g == 0) ? B0_WORDS : (g == 1) ? B1_WORDS :
                                 (g == 2) ? B2_WORDS : B4_WORDS;
    localparam int unsigned DW = (g == 3) ? 14 : 12;

    assign we_first[g] = accept && first  && (bank == bank_e'(g));
    assign we_cont[g]  = accept && !first && (bank == bank_e'(g));

    prog_bank #(.IDX(g), .WORDS(NW), .DW(DW)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .first_i   (we_first[g]),
      .cont_i    (we_cont[g]),
      .field_i   (field),
      .rd_word_i (rd_word_i),
      .rd_data_o (rd_all[g]),
      .can_cont_o(can_cont[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (reject)    err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign ready_o   = ready;
  assign err_o     = err_q;
  assign rd_data_o = rd_all[rd_bank_i];

  a_r6_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);
  a_r7_busy_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ready_o) |=> err_o);
  a_r5_reserved_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[14:12] == 3'b111) |=> err_o);
  a_r12_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
endmodule

// File: tb/prog_port_tb.sv
module prog_port_tb;
  localparam int BUSY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rx_en = 1'b0, tx_en = 1'b0, proc_en = 1'b1, clk_en = 1'b1, ovr_en = 1'b1;
  logic        err_clr = 1'b0;
  logic [1:0]  rd_bank = '0;
  logic [3:0]  rd_word = '0;
  logic        ready, err;
  logic [13:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #2ns clk = ~clk;

  prog_port #(.BUSY_CYC(BUSY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rx_en_i(rx_en), .tx_en_i(tx_en), .proc_en_i(proc_en), .clk_en_i(clk_en),
    .ovr_en_i(ovr_en), .err_clr_i(err_clr), .rd_bank_i(rd_bank), .rd_word_i(rd_word),
    .ready_o(ready), .err_o(err), .rd_data_o(rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int dflt(input int b, input int w);
    return b * 256 + w;
  endfunction

  task automatic peek(input int b, input int w, output int v);
    rd_bank = 2'(b);
    rd_word = 4'(w);
    #1ns;
    v = int'(rd_data);
  endtask

  task automatic check_slot(input string tag, input int b, input int w, input int exp);
    int v;
    peek(b, w, v);
    check(tag, v, exp);
  endtask

  task automatic raw_write(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100 && !ready; i++) @(negedge clk);
  endtask

  task automatic put(input logic [15:0] d);
    raw_write(d);
    wait_ready();
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check("R12 clear", int'(err), 0);
  endtask

  task automatic t_reset();
    check("R1 ready", int'(ready), 1);
    check("R1 err", int'(err), 0);
    check_slot("R1 b0w0", 0, 0, dflt(0, 0));
    check_slot("R1 b2w3", 2, 3, dflt(2, 3));
    check_slot("R1 b4w7", 3, 7, dflt(3, 7));
  endtask

  task automatic t_timing_and_seq();
    raw_write(16'hC123);
    check("R6 low", int'(ready), 0);
    repeat (BUSY - 1) @(posedge clk);
    @(negedge clk);
    check("R6 still low", int'(ready), 0);
    @(posedge clk);
    @(negedge clk);
    check("R6 back", int'(ready), 1);
    check_slot("R2 b0w0", 0, 0, 16'h123);
    put(16'h4456);
    check_slot("R3 b0w1", 0, 1, 16'h456);
    check("R3 no err", int'(err), 0);
  endtask

  task automatic t_decode();
    put(16'hAABC);
    check_slot("R4 b4w0", 3, 0, 16'h2ABC);
    put(16'h3FFF);
    check_slot("R4 b4w1", 3, 1, 16'h3FFF);
    put(16'hDFFF);
    check_slot("R4 b1w0", 1, 0, 16'h0FFF);
    check_slot("R4 b2 untouched", 2, 0, dflt(2, 0));
  endtask

  task automatic t_reserved();
    raw_write(16'hF055);
    check("R5 err", int'(err), 1);
    check("R5 ready kept", int'(ready), 1);
    @(negedge clk);
    check("R12 sticky", int'(err), 1);
    clear_err();
  endtask

  task automatic t_busy_write();
    raw_write(16'hD111);
    raw_write(16'hD222);
    check("R7 err", int'(err), 1);
    wait_ready();
    check_slot("R7 kept", 1, 0, 16'h111);
    clear_err();
  endtask

  task automatic t_no_open();
    raw_write(16'h6777);
    check("R9 err", int'(err), 1);
    check_slot("R9 slot", 2, 1, dflt(2, 1));
    clear_err();
  endtask

  task automatic t_permission();
    for (int k = 0; k < 5; k++) begin
      rx_en = (k == 0); tx_en = (k == 1);
      proc_en = (k != 2); clk_en = (k != 3); ovr_en = (k != 4);
      raw_write(16'hE5A5);
      check($sformatf("R8 err case %0d", k), int'(err), 1);
      check_slot("R8 slot", 2, 0, dflt(2, 0));
      rx_en = 1'b0; tx_en = 1'b0; proc_en = 1'b1; clk_en = 1'b1; ovr_en = 1'b1;
      clear_err();
    end
  endtask

  task automatic t_overflow();
    put(16'h8000);
    for (int w = 1; w < 8; w++) put(16'(16'h0010 + w));
    check("R10 no err yet", int'(err), 0);
    check_slot("R10 b4w7", 3, 7, 16'h17);
    raw_write(16'h0099);
    check("R10 b4 over err", int'(err), 1);
    check("R10 ready kept", int'(ready), 1);
    check_slot("R10 b4w0 kept", 3, 0, 0);
    clear_err();
    for (int w = 1; w < 4; w++) put(16'(16'h5020 + w));
    check_slot("R10 b1w3", 1, 3, 16'h23);
    raw_write(16'h5044);
    check("R10 b1 over err", int'(err), 1);
    clear_err();
  endtask

  task automatic t_interleave();
    put(16'h5333);
    check("R11 b1 full err", int'(err), 1);
    clear_err();
    put(16'hC0AA);
    put(16'hD0BB);
    put(16'h40CC);
    check_slot("R11 b0w0", 0, 0, 16'hAA);
    check_slot("R11 b0w1", 0, 1, 16'hCC);
    check_slot("R11 b0w2 untouched", 0, 2, dflt(0, 2));
    check_slot("R11 b1w0", 1, 0, 16'hBB);
    check_slot("R11 b1w1 kept", 1, 1, 16'h21);
    put(16'h50DD);
    check_slot("R11 b1w1 new", 1, 1, 16'hDD);
    put(16'h40EE);
    check_slot("R11 b0w2", 0, 2, 16'hEE);
    check("R11 no err", int'(err), 0);
  endtask

  initial begin
    #400us;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing_and_seq();
    t_decode();
    t_reserved();
    t_busy_write();
    t_no_open();
    t_permission();
    t_overflow();
    t_interleave();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule